// File: doc/BRIEF.md
# Partitioned SIMD Integer ALU

This block is an integer ALU for 64-bit operands. It can treat each operand as eight bytes, four halfwords, two words or one 64-bit value. It applies one operation to every lane at once, and no lane affects its neighbour. The caller chooses the operation, the lane size and the signedness. A further input chooses between clamping arithmetic and ordinary two's-complement wraparound.

Besides add and subtract, the lane operations are min, max, absolute value and a rounding average. A reduction sums the absolute lane differences into one scalar. The plain bitwise operations ignore lanes entirely. Each accepted input produces its result one clock later, and the output valid flag is delayed to match.

Top module: `simd_alu`

## Requirements
- R1: `valid_o` equals `valid_i` of the previous cycle. A result computed from inputs presented with `valid_i` high appears on `result_o` in the cycle after the clock edge that samples them.
- R2: While `rst_ni` is low, `valid_o` and `result_o` are zero, whatever the other inputs are.
- R3: `opcode_i` uses this encoding:
  - 0 add, 1 subtract, 2 min, 3 max, 4 absolute value of A, 5 average
  - 6 sum of absolute differences
  - 7 and, 8 or, 9 xor, 10 invert A, 11 A and-not B
  - Codes 12 to 15 give a zero result.
- R4: `lane_sz_i` selects the lane width: 0 for 8 bits, 1 for 16, 2 for 32 and 3 for 64. Lane k occupies bits [k*W +: W]. No carry, borrow or clamp crosses a lane boundary.
- R5: With `sat_i` low, add and subtract return the low W bits of the true lane result.
- R6: With `sat_i` high, add and subtract clamp to the lane's range. When `signed_i` is high that range is -2^(W-1) to 2^(W-1)-1. When `signed_i` is low it is 0 to 2^W-1.
- R7: Min and max compare lanes as two's-complement values when `signed_i` is high, and as unsigned values otherwise.
- R8: Absolute value with `signed_i` high negates negative lanes. The most negative value becomes the maximum positive value when `sat_i` is high, and stays unchanged when `sat_i` is low. With `signed_i` low, A is returned unchanged.
- R9: Average returns floor((a+b+1)/2) per lane. The result is exact, with no intermediate overflow, in both signed and unsigned interpretation.
- R10: Sum of absolute differences adds |a-b| over all lanes, under the selected signedness. The sum is zero-extended to 64 bits, so 8-bit lanes never set bits above bit 10.
- R11: The bitwise operations act on all 64 bits. They ignore `lane_sz_i`, `signed_i` and `sat_i`.
- R12: When `valid_i` is low, `result_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input operands are valid |
| op_a_i | input | 64 | Operand A |
| op_b_i | input | 64 | Operand B |
| lane_sz_i | input | 2 | Lane width code |
| signed_i | input | 1 | Signed lane interpretation |
| sat_i | input | 1 | Clamp instead of wrap |
| opcode_i | input | 4 | Operation code |
| valid_o | output | 1 | Result is valid |
| result_o | output | 64 | Registered result |

## Verification
The only internal state is the output register and its valid flag. A wrong captured value therefore shows at the ports in the cycle after the input that caused it. A missed hold shows one cycle after the first idle input. A lane that leaks a carry or a clamp into its neighbour corrupts the adjacent lane field of that same registered result. Directed vectors that sit on lane and range boundaries expose such a leak. Long random streams, compared every clock, cover the rest of the operation and width space.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  localparam int DATA_W  = 64;
  localparam int N_SIZES = 4;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_MIN  = 4'd2,
    OP_MAX  = 4'd3,
    OP_ABS  = 4'd4,
    OP_AVG  = 4'd5,
    OP_SAD  = 4'd6,
    OP_AND  = 4'd7,
    OP_OR   = 4'd8,
    OP_XOR  = 4'd9,
    OP_NOT  = 4'd10,
    OP_ANDN = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {
    LANE_8  = 2'd0,
    LANE_16 = 2'd1,
    LANE_32 = 2'd2,
    LANE_64 = 2'd3
  } lane_sz_e;
endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   op_i,
  input  logic         sgn_i,
  input  logic         sat_i,
  output logic [W-1:0] res_o,
  output logic [W-1:0] adiff_o
);
  // two guard bits keep sum, difference and negation exact
  localparam int EW = W + 2;

  logic signed [EW-1:0] ea, eb, sum, dif, neg_a, avg, dmag;
  logic signed [EW-1:0] max_v, min_v, arith;
  logic                 clamp_en;

  always_comb begin
    ea    = {{2{sgn_i & a_i[W-1]}}, a_i};
    eb    = {{2{sgn_i & b_i[W-1]}}, b_i};
    sum   = ea + eb;
    dif   = ea - eb;
    neg_a = -ea;
    avg   = (sum + EW'(1)) >>> 1;
    dmag  = dif[EW-1] ? -dif : dif;
    max_v = sgn_i ? {3'b000, {(W-1){1'b1}}} : {2'b00, {W{1'b1}}};
    min_v = sgn_i ? {3'b111, {(W-1){1'b0}}} : '0;
  end

  always_comb begin
    arith    = '0;
    clamp_en = 1'b0;
    case (op_i)
      OP_ADD: begin arith = sum; clamp_en = sat_i; end
      OP_SUB: begin arith = dif; clamp_en = sat_i; end
      OP_MIN: arith = (ea < eb) ? ea : eb;
      OP_MAX: arith = (ea < eb) ? eb : ea;
      OP_ABS: begin arith = ea[EW-1] ? neg_a : ea; clamp_en = sat_i; end
      OP_AVG: arith = avg;
      default: arith = '0;
    endcase
  end

  always_comb begin
    if (clamp_en && (arith > max_v))      res_o = max_v[W-1:0];
    else if (clamp_en && (arith < min_v)) res_o = min_v[W-1:0];
    else                                  res_o = arith[W-1:0];
  end

  assign adiff_o = dmag[W-1:0];
endmodule

// File: rtl/simd_lane_bank.sv
module simd_lane_bank
  import simd_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [3:0]        op_i,
  input  logic              sgn_i,
  input  logic              sat_i,
  output logic [DATA_W-1:0] res_o,
  output logic [DATA_W-1:0] sad_o
);
  localparam int N_LANES = DATA_W / W;

  logic [N_LANES-1:0][W-1:0] lane_res;
  logic [N_LANES-1:0][W-1:0] lane_ad;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    simd_lane #(.W(W)) u_lane (
      .a_i    (a_i[g*W +: W]),
      .b_i    (b_i[g*W +: W]),
      .op_i   (op_i),
      .sgn_i  (sgn_i),
      .sat_i  (sat_i),
      .res_o  (lane_res[g]),
      .adiff_o(lane_ad[g])
    );
  end

  assign res_o = lane_res;

  always_comb begin
    sad_o = '0;
    for (int i = 0; i < N_LANES; i++) sad_o = sad_o + DATA_W'(lane_ad[i]);
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [1:0]        lane_sz_i,
  input  logic              signed_i,
  input  logic              sat_i,
  input  logic [3:0]        opcode_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  logic [N_SIZES-1:0][DATA_W-1:0] bank_res;
  logic [N_SIZES-1:0][DATA_W-1:0] bank_sad;
  logic [DATA_W-1:0]              nxt_res;

  for (genvar s = 0; s < N_SIZES; s++) begin : g_bank
    simd_lane_bank #(.W(8 << s)) u_bank (
      .a_i  (op_a_i),
      .b_i  (op_b_i),
      .op_i (opcode_i),
      .sgn_i(signed_i),
      .sat_i(sat_i),
      .res_o(bank_res[s]),
      .sad_o(bank_sad[s])
    );
  end

  always_comb begin
    case (opcode_i)
      OP_ADD, OP_SUB, OP_MIN, OP_MAX, OP_ABS, OP_AVG:
                nxt_res = bank_res[lane_sz_i];
      OP_SAD:   nxt_res = bank_sad[lane_sz_i];
      OP_AND:   nxt_res = op_a_i & op_b_i;
      OP_OR:    nxt_res = op_a_i | op_b_i;
      OP_XOR:   nxt_res = op_a_i ^ op_b_i;
      OP_NOT:   nxt_res = ~op_a_i;
      OP_ANDN:  nxt_res = op_a_i & ~op_b_i;
      default:  nxt_res = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= nxt_res;
    end
  end
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk
  import simd_alu_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] op_a_i,
  input logic [DATA_W-1:0] op_b_i,
  input logic [1:0]        lane_sz_i,
  input logic              signed_i,
  input logic              sat_i,
  input logic [3:0]        opcode_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1
  AST_IDLE_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)); // R12
  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i > 4'd11) |=> result_o == '0); // R3
  AST_AND_LANE_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i == OP_AND) |=> result_o == ($past(op_a_i) & $past(op_b_i))); // R11
  AST_INVERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i == OP_NOT) |=> result_o == ~$past(op_a_i)); // R11
  AST_UABS_IDENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i == OP_ABS && !signed_i) |=> result_o == $past(op_a_i)); // R8
  AST_SAD_BYTE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i == OP_SAD && lane_sz_i == 2'd0) |=> result_o[63:11] == '0); // R10
endmodule

bind simd_alu simd_alu_chk u_chk (.*);

// File: tb/simd_alu_tb.sv
`timescale 1ns/1ps
module simd_alu_tb;
  import simd_alu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i;
  logic [63:0] op_a, op_b;
  logic [1:0]  lane_sz;
  logic        sgn, sat;
  logic [3:0]  opc;
  logic        valid_o;
  logic [63:0] result_o;

  int          n_cmp = 0;
  int          n_bad = 0;
  logic        exp_v;
  logic [63:0] exp_r;

  always #2 clk = ~clk;

  simd_alu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_a_i(op_a), .op_b_i(op_b),
    .lane_sz_i(lane_sz), .signed_i(sgn), .sat_i(sat), .opcode_i(opc),
    .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic [63:0] ref_alu(logic [63:0] a, logic [63:0] b, logic [1:0] sz,
                                          logic sg, logic st, logic [3:0] op);
    int w, n;
    logic [63:0] m, ua, ub, out, sad;
    logic signed [69:0] x, y, r, hi, lo, d;
    case (op)
      4'd7:  return a & b;
      4'd8:  return a | b;
      4'd9:  return a ^ b;
      4'd10: return ~a;
      4'd11: return a & ~b;
      default: ;
    endcase
    if (op > 4'd11) return 64'd0;
    w = 8 << sz; n = 64 / w;
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    out = '0; sad = '0;
    for (int i = 0; i < n; i++) begin
      ua = (a >> (i * w)) & m;
      ub = (b >> (i * w)) & m;
      x = $signed({6'b0, ua});
      y = $signed({6'b0, ub});
      if (sg && ua[w-1]) x = x - (70'sd1 <<< w);
      if (sg && ub[w-1]) y = y - (70'sd1 <<< w);
      hi = sg ? (70'sd1 <<< (w - 1)) - 70'sd1 : (70'sd1 <<< w) - 70'sd1;
      lo = sg ? -(70'sd1 <<< (w - 1)) : 70'sd0;
      case (op)
        4'd0: r = x + y;
        4'd1: r = x - y;
        4'd2: r = (x < y) ? x : y;
        4'd3: r = (x > y) ? x : y;
        4'd4: r = (x < 0) ? -x : x;
        4'd5: r = (x + y + 70'sd1) >>> 1;
        default: r = 70'sd0;
      endcase
      if (st && (op <= 4'd1 || op == 4'd4)) begin
        if (r > hi) r = hi;
        if (r < lo) r = lo;
      end
      d = x - y;
      if (d < 0) d = -d;
      sad = sad + d[63:0];
      out = out | ((r[63:0] & m) << (i * w));
    end
    return (op == 4'd6) ? sad : out;
  endfunction

  function automatic string tag_of(logic [3:0] op, logic st);
    case (op)
      4'd0, 4'd1: return st ? "R1/R6" : "R1/R5";
      4'd2, 4'd3: return "R1/R7";
      4'd4:       return "R1/R8";
      4'd5:       return "R1/R9";
      4'd6:       return "R1/R10";
      4'd7, 4'd8, 4'd9, 4'd10, 4'd11: return "R1/R11";
      default:    return "R1/R3";
    endcase
  endfunction

  task automatic compare(string tag);
    n_cmp++;
    if (valid_o !== exp_v || result_o !== exp_r) begin
      n_bad++;
      $display("FAIL %s: valid=%0b result=%h expected valid=%0b result=%h",
               tag, valid_o, result_o, exp_v, exp_r);
    end
  endtask

  // call right after a falling edge; compares at the next falling edge
  task automatic step(logic v, logic [63:0] a, logic [63:0] b, logic [1:0] sz,
                      logic sg, logic st, logic [3:0] op, string tag);
    valid_i = v; op_a = a; op_b = b; lane_sz = sz; sgn = sg; sat = st; opc = op;
    if (v) exp_r = ref_alu(a, b, sz, sg, st, op);
    exp_v = v;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; valid_i = 1'b1; op_a = '1; op_b = 64'h5; lane_sz = 2'd0;
    sgn = 1'b0; sat = 1'b0; opc = 4'd0;
    exp_v = 1'b0; exp_r = '0;
    repeat (3) begin @(negedge clk); compare("R2"); end
    rst_n = 1'b1;
    // lane isolation at every width (R4)
    step(1, 64'h0000_0000_0000_00FF, 64'h1, 2'd0, 0, 0, 4'd0, "R4");
    step(1, 64'h0000_0000_0000_00FF, 64'h1, 2'd1, 0, 0, 4'd0, "R4");
    step(1, 64'h0000_0000_FFFF_FFFF, 64'h1, 2'd2, 0, 0, 4'd0, "R4");
    step(1, 64'h0000_0000_FFFF_FFFF, 64'h1, 2'd3, 0, 0, 4'd0, "R4");
    step(1, 64'h0100_0000_0000_0000, 64'h0000_0000_0000_0001, 2'd0, 0, 0, 4'd1, "R4/R5");
    // clamping (R6)
    step(1, 64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 2'd0, 1, 1, 4'd0, "R6");
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 2'd1, 0, 1, 4'd0, "R6");
    step(1, 64'h0, 64'h1, 2'd2, 0, 1, 4'd1, "R6");
    step(1, 64'h8000_0000_0000_0000, 64'h1, 2'd3, 1, 1, 4'd1, "R6");
    step(1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 2'd3, 1, 1, 4'd0, "R6");
    // min/max signedness (R7)
    step(1, 64'h80, 64'h01, 2'd0, 1, 0, 4'd2, "R7");
    step(1, 64'h80, 64'h01, 2'd0, 0, 0, 4'd2, "R7");
    step(1, 64'h8000_0001, 64'h1, 2'd2, 1, 0, 4'd3, "R7");
    // absolute value (R8)
    step(1, 64'h8080_8080_8080_8080, 64'h0, 2'd0, 1, 1, 4'd4, "R8");
    step(1, 64'h8080_8080_8080_8080, 64'h0, 2'd0, 1, 0, 4'd4, "R8");
    step(1, 64'h8080_8080_8080_8080, 64'h0, 2'd0, 0, 1, 4'd4, "R8");
    // average (R9)
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'd0, 0, 0, 4'd5, "R9");
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE, 2'd3, 1, 0, 4'd5, "R9");
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 0, 0, 4'd5, "R9");
    // sum of absolute differences (R10)
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 2'd0, 0, 0, 4'd6, "R10");
    step(1, 64'h7F7F_7F7F_7F7F_7F7F, 64'h8080_8080_8080_8080, 2'd0, 1, 0, 4'd6, "R10");
    step(1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 0, 0, 4'd6, "R10");
    // bitwise ignores lane controls (R11)
    step(1, 64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_AAAA, 2'd1, 1, 1, 4'd11, "R11");
    step(1, 64'hF0F0_1234_5678_9ABC, 64'h0, 2'd2, 1, 1, 4'd10, "R11");
    // unused codes (R3), then idle hold (R12)
    step(1, 64'h1234, 64'h5678, 2'd0, 0, 0, 4'd15, "R3");
    step(1, 64'hDEAD_BEEF, 64'h1, 2'd0, 0, 0, 4'd0, "R5");
    step(0, 64'h1111, 64'h2222, 2'd0, 0, 0, 4'd1, "R12");
    step(0, '1, '1, 2'd3, 1, 1, 4'd8, "R12");
    // random stream
    for (int k = 0; k < 4000; k++) begin
      logic        rv = ($urandom_range(3) != 0);
      logic [3:0]  rop = 4'($urandom_range(15));
      logic        rst = 1'($urandom);
      logic [63:0] ra = {$urandom, $urandom};
      logic [63:0] rb = {$urandom, $urandom};
      if ($urandom_range(7) == 0) rb = ra ^ 64'h8080_8080_8080_8080;
      step(rv, ra, rb, 2'($urandom_range(3)), 1'($urandom), rst, rop,
           rv ? tag_of(rop, rst) : "R12");
    end
    summary();
    $finish;
  end
endmodule